// File: doc/BRIEF.md
# PWM Compare and Action Qualifier

This block sits behind a PWM time-base counter. Each clock it receives the counter value, its counting direction and the zero and period events. It compares the count with two 16-bit compare values, A and B. From the events it finds, it drives two PWM output pins. A compare value can be written straight into its active register. It can also be written into a shadow register, which is then copied into the active register on a time-base event that software selects. This lets a new duty value take effect at a clean point in the PWM period.

Each output has a 10-bit action word. The word holds one 2-bit action code for each of three events: counter zero, compare-A match while counting up, and compare-B match while counting up. Each code means no change, drive low, drive high or toggle. With the usual setup, an output goes high at zero and goes low at its compare match. The duty cycle is then the compare value divided by (period + 1), so a compare value of 0 gives a 0% duty cycle. Compare values must not exceed the period.

Top module: `pwm_cmp_aq`

## Requirements
- R1: While reset is high, and on the clock edges at which it is high, both outputs go low and both the active and shadow compare registers become 0.
- R2: When a channel's shadow mode input is 0, a compare write loads the active register at that clock edge. The new value is used for matching from the next cycle.
- R3: When shadow mode is 1, a write goes to the shadow register only. The active register takes the shadow value at an edge where the load event occurs. The load-select encoding is: 0 for counter zero, 1 for count equal to period, 2 for either event. On an edge where a write and a load happen together, the active register takes the shadow value from before that write.
- R4: With shadow mode 1 and load-select 3, the active register never changes, whatever is written.
- R5: A compare event for a channel happens only on a cycle where the up-direction input is 1 and the count equals that channel's active value. While counting down, no compare event happens.
- R6: In an action word, bits 1:0 hold the zero action, bits 5:4 the compare-A action and bits 9:8 the compare-B action. The action codes are 0 for no change, 1 for low, 2 for high and 3 for toggle.
- R7: When several events happen on the same cycle, only the highest-priority one takes effect, even if its code is 0. Compare B has the highest priority, then compare A, then zero.
- R8: With zero=high and own-compare=low on an up counter with period P, an output is high for C of every P+1 cycles. C=0 keeps the output always low, and C=P keeps it low only at count P.
- R9: An output changes only at the clock edge that samples an event whose selected action changes it. It holds its value on every other edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one time-base tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tb_count | input | 16 | Time-base counter value |
| tb_up | input | 1 | 1 while the counter counts up |
| tb_zero | input | 1 | Counter-zero event |
| tb_period | input | 1 | Counter-equals-period event |
| wr_a | input | 1 | Compare A write strobe |
| wr_data_a | input | 16 | Compare A write value |
| shadow_en_a | input | 1 | Compare A shadow mode |
| load_sel_a | input | 2 | Compare A shadow load event select |
| wr_b | input | 1 | Compare B write strobe |
| wr_data_b | input | 16 | Compare B write value |
| shadow_en_b | input | 1 | Compare B shadow mode |
| load_sel_b | input | 2 | Compare B shadow load event select |
| act_word_a | input | 10 | Action word for output A |
| act_word_b | input | 10 | Action word for output B |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
Duty cycles are checked on an up counter with mid-range compare values and with the extremes 0 and period. This separates a correct match and action path from errors of one count or a wrong polarity. Shadow writes placed mid-period under each load select show whether a reload happens on the right event, on a different event, or never (frozen). An up-down counter with toggle actions shows that compare matches are ignored while counting down. Action words whose events coincide at count zero reveal the priority order among compare B, compare A and zero, including a top-priority code of 0.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'd0,
        ACT_LOW    = 2'd1,
        ACT_HIGH   = 2'd2,
        ACT_TOGGLE = 2'd3
    } aq_act_e;

    typedef enum logic [1:0] {
        LD_ZERO   = 2'd0,
        LD_PERIOD = 2'd1,
        LD_EITHER = 2'd2,
        LD_FROZEN = 2'd3
    } load_sel_e;

    typedef struct packed {
        aq_act_e on_cmp_b;
        logic [1:0] rsv1;
        aq_act_e on_cmp_a;
        logic [1:0] rsv0;
        aq_act_e on_zero;
    } act_word_t;

    localparam int unsigned NUM_CH = 2;

    function automatic logic load_due(load_sel_e sel, logic ev_zero, logic ev_prd);
        case (sel)
            LD_ZERO:   return ev_zero;
            LD_PERIOD: return ev_prd;
            LD_EITHER: return ev_zero | ev_prd;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic aq_act_e pick_act(act_word_t w, logic ev_zero, logic ev_a, logic ev_b);
        if (ev_b)
            return w.on_cmp_b;
        else if (ev_a)
            return w.on_cmp_a;
        else if (ev_zero)
            return w.on_zero;
        return ACT_NONE;
    endfunction

    function automatic logic apply_act(aq_act_e a, logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

endpackage

// File: rtl/pwm_cmp_reg.sv
module pwm_cmp_reg
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [CW-1:0] wr_data,
    input  logic          shadow_en,
    input  load_sel_e     load_sel,
    input  logic          ev_zero,
    input  logic          ev_prd,
    input  logic [CW-1:0] count,
    input  logic          up,
    output logic [CW-1:0] active,
    output logic          match
);

    logic [CW-1:0] shadow_q;
    logic          reload;

    assign reload = shadow_en && load_due(load_sel, ev_zero, ev_prd);
    assign match  = up && (count == active);

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active   <= '0;
        end else begin
            if (wr && shadow_en)
                shadow_q <= wr_data;
            if (wr && !shadow_en)
                active <= wr_data;
            else if (reload)
                active <= shadow_q;
        end
    end

endmodule

// File: rtl/pwm_aq_out.sv
module pwm_aq_out
    import pwm_aq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  act_word_t word,
    input  logic      ev_zero,
    input  logic      ev_a,
    input  logic      ev_b,
    output logic      pin
);

    aq_act_e sel_act;

    assign sel_act = pick_act(word, ev_zero, ev_a, ev_b);

    always_ff @(posedge clk) begin
        if (rst)
            pin <= 1'b0;
        else
            pin <= apply_act(sel_act, pin);
    end

endmodule

// File: rtl/pwm_cmp_aq.sv
module pwm_cmp_aq
    import pwm_aq_pkg::*;
#(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] tb_count,
    input  logic          tb_up,
    input  logic          tb_zero,
    input  logic          tb_period,
    input  logic          wr_a,
    input  logic [CW-1:0] wr_data_a,
    input  logic          shadow_en_a,
    input  logic [1:0]    load_sel_a,
    input  logic          wr_b,
    input  logic [CW-1:0] wr_data_b,
    input  logic          shadow_en_b,
    input  logic [1:0]    load_sel_b,
    input  logic [9:0]    act_word_a,
    input  logic [9:0]    act_word_b,
    output logic          pwm_a,
    output logic          pwm_b
);

    logic [NUM_CH-1:0]         ch_wr;
    logic [NUM_CH-1:0]         ch_shadow;
    logic [NUM_CH-1:0][CW-1:0] ch_data;
    logic [NUM_CH-1:0][1:0]    ch_lsel;
    logic [NUM_CH-1:0][CW-1:0] active;
    logic [NUM_CH-1:0]         match;
    logic [NUM_CH-1:0][9:0]    words;
    logic [NUM_CH-1:0]         pins;

    assign ch_wr     = {wr_b, wr_a};
    assign ch_shadow = {shadow_en_b, shadow_en_a};
    assign ch_data   = {wr_data_b, wr_data_a};
    assign ch_lsel   = {load_sel_b, load_sel_a};
    assign words     = {act_word_b, act_word_a};

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwm_cmp_reg #(.CW(CW)) cmp_i (
            .clk       (clk),
            .rst       (rst),
            .wr        (ch_wr[c]),
            .wr_data   (ch_data[c]),
            .shadow_en (ch_shadow[c]),
            .load_sel  (load_sel_e'(ch_lsel[c])),
            .ev_zero   (tb_zero),
            .ev_prd    (tb_period),
            .count     (tb_count),
            .up        (tb_up),
            .active    (active[c]),
            .match     (match[c])
        );

        pwm_aq_out out_i (
            .clk     (clk),
            .rst     (rst),
            .word    (act_word_t'(words[c])),
            .ev_zero (tb_zero),
            .ev_a    (match[0]),
            .ev_b    (match[1]),
            .pin     (pins[c])
        );
    end

    assign pwm_a = pins[0];
    assign pwm_b = pins[1];

endmodule

// File: rtl/pwm_cmp_aq_chk.sv
module pwm_cmp_aq_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          tb_up,
    input logic          tb_zero,
    input logic          wr_a,
    input logic [CW-1:0] wr_data_a,
    input logic          shadow_en_a,
    input logic [1:0]    load_sel_a,
    input logic [9:0]    act_word_a,
    input logic [CW-1:0] act0,
    input logic          m0,
    input logic          m1,
    input logic          pwm_a,
    input logic          pwm_b
);

    logic rst_seen = 1'b0;

    always_ff @(posedge clk) begin
        rst_seen <= rst;
        if (rst_seen) begin
            assert_reset_low_R1: assert (!pwm_a && !pwm_b);
        end
    end

    assert_imm_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_a && !shadow_en_a) |=> (act0 == $past(wr_data_a)));

    assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (shadow_en_a && load_sel_a == 2'd3) |=> $stable(act0));

    assert_no_down_match_R5: assert property (@(posedge clk) disable iff (rst)
        !tb_up |-> (!m0 && !m1));

    assert_zero_set_R6: assert property (@(posedge clk) disable iff (rst)
        (tb_zero && !m0 && !m1 && act_word_a[1:0] == 2'd2) |=> pwm_a);

    assert_cmpa_toggle_R6: assert property (@(posedge clk) disable iff (rst)
        (m0 && !m1 && act_word_a[5:4] == 2'd3) |=> (pwm_a != $past(pwm_a)));

    assert_cmpb_first_R7: assert property (@(posedge clk) disable iff (rst)
        (m1 && act_word_a[9:8] == 2'd1) |=> !pwm_a);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!tb_zero && !m0 && !m1) |=> $stable(pwm_a));

endmodule

bind pwm_cmp_aq pwm_cmp_aq_chk #(.CW(CW)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .tb_up       (tb_up),
    .tb_zero     (tb_zero),
    .wr_a        (wr_a),
    .wr_data_a   (wr_data_a),
    .shadow_en_a (shadow_en_a),
    .load_sel_a  (load_sel_a),
    .act_word_a  (act_word_a),
    .act0        (active[0]),
    .m0          (match[0]),
    .m1          (match[1]),
    .pwm_a       (pwm_a),
    .pwm_b       (pwm_b)
);

// File: tb/pwm_cmp_aq_tb_top.sv
module pwm_cmp_aq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tb_count = '0;
    logic        tb_up = 1'b1;
    logic        tb_zero = 1'b0;
    logic        tb_period = 1'b0;
    logic        wr_a = 1'b0, wr_b = 1'b0;
    logic [15:0] wr_data_a = '0, wr_data_b = '0;
    logic        shadow_en_a = 1'b0, shadow_en_b = 1'b0;
    logic [1:0]  load_sel_a = 2'd0, load_sel_b = 2'd0;
    logic [9:0]  act_word_a = '0, act_word_b = '0;
    logic        pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";

    int period = 9;
    bit updown = 1'b0;
    int cnt = 0;
    bit dir_up = 1'b1;

    int m_act [2];
    int m_shd [2];
    bit m_out [2];

    always #10 clk = ~clk;

    pwm_cmp_aq #(.CW(16)) dut_i (
        .clk(clk), .rst(rst), .tb_count(tb_count), .tb_up(tb_up),
        .tb_zero(tb_zero), .tb_period(tb_period),
        .wr_a(wr_a), .wr_data_a(wr_data_a), .shadow_en_a(shadow_en_a), .load_sel_a(load_sel_a),
        .wr_b(wr_b), .wr_data_b(wr_data_b), .shadow_en_b(shadow_en_b), .load_sel_b(load_sel_b),
        .act_word_a(act_word_a), .act_word_b(act_word_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    function automatic int field(logic [9:0] w, int sh);
        return int'((w >> sh) & 10'd3);
    endfunction

    function automatic bit do_act(int code, bit cur);
        if (code == 1) return 1'b0;
        if (code == 2) return 1'b1;
        if (code == 3) return !cur;
        return cur;
    endfunction

    function automatic bit due(int sel, bit z, bit p);
        if (sel == 0) return z;
        if (sel == 1) return p;
        if (sel == 2) return z || p;
        return 1'b0;
    endfunction

    // Behavioural model of one edge; R9: outputs move only on a chosen action.
    task automatic model_edge();
        bit ma, mb;
        int code;
        logic [9:0] w;
        bit wr [2];
        bit se [2];
        int wd [2];
        int ls [2];
        if (rst) begin
            for (int c = 0; c < 2; c++) begin
                m_act[c] = 0; m_shd[c] = 0; m_out[c] = 1'b0;
            end
            return;
        end
        ma = tb_up && (int'(tb_count) == m_act[0]);
        mb = tb_up && (int'(tb_count) == m_act[1]);
        for (int c = 0; c < 2; c++) begin
            w = (c == 0) ? act_word_a : act_word_b;
            if (mb) code = field(w, 8);
            else if (ma) code = field(w, 4);
            else if (tb_zero) code = field(w, 0);
            else code = 0;
            m_out[c] = do_act(code, m_out[c]);
        end
        wr[0] = wr_a; wr[1] = wr_b; se[0] = shadow_en_a; se[1] = shadow_en_b;
        wd[0] = int'(wr_data_a); wd[1] = int'(wr_data_b);
        ls[0] = int'(load_sel_a); ls[1] = int'(load_sel_b);
        for (int c = 0; c < 2; c++) begin
            int old_shd;
            old_shd = m_shd[c];
            if (wr[c] && se[c]) m_shd[c] = wd[c];
            if (wr[c] && !se[c]) m_act[c] = wd[c];
            else if (se[c] && due(ls[c], tb_zero, tb_period)) m_act[c] = old_shd;
        end
    endtask

    task automatic tick();
        tb_count  = 16'(cnt);
        tb_up     = dir_up;
        tb_zero   = (cnt == 0);
        tb_period = (cnt == period);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        checks++;
        if (pwm_a !== m_out[0]) begin
            errors++;
            $display("FAIL %s pwm_a actual %0b expected %0b at count %0d", tag, pwm_a, m_out[0], cnt);
        end
        checks++;
        if (pwm_b !== m_out[1]) begin
            errors++;
            $display("FAIL %s pwm_b actual %0b expected %0b at count %0d", tag, pwm_b, m_out[1], cnt);
        end
        wr_a = 1'b0;
        wr_b = 1'b0;
        if (!updown) begin
            dir_up = 1'b1;
            cnt = (cnt >= period) ? 0 : cnt + 1;
        end else if (dir_up) begin
            if (cnt >= period) begin dir_up = 1'b0; cnt = period - 1; end
            else cnt = cnt + 1;
        end else begin
            if (cnt == 0) begin dir_up = 1'b1; cnt = 1; end
            else cnt = cnt - 1;
        end
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wa(int v);
        wr_a = 1'b1; wr_data_a = 16'(v);
    endtask

    task automatic wb(int v);
        wr_b = 1'b1; wr_data_b = 16'(v);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired in phase %s", tag);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        @(negedge clk);
        tag = "R1";
        rst = 1'b1;
        act_word_a = 10'h012;
        act_word_b = 10'h102;
        run(3);
        rst = 1'b0;
        act_word_a = 10'h000;
        act_word_b = 10'h000;
        cnt = 0;
        run(4);

        tag = "R2";
        act_word_a = 10'h012;
        act_word_b = 10'h102;
        wa(3); wb(6);
        run(30);
        wa(8);
        run(20);

        tag = "R8";
        wa(0); wb(9);
        run(25);

        tag = "R3";
        wa(4); wb(4);
        run(5);
        shadow_en_a = 1'b1; shadow_en_b = 1'b1;
        load_sel_a = 2'd0; load_sel_b = 2'd1;
        run(3);
        wa(6); wb(2);
        run(25);
        load_sel_a = 2'd1; load_sel_b = 2'd2;
        run(4);
        wa(2); wb(7);
        run(25);
        load_sel_a = 2'd2; load_sel_b = 2'd0;
        wa(5); wb(3);
        run(25);

        tag = "R4";
        load_sel_a = 2'd3; load_sel_b = 2'd3;
        wa(1); wb(8);
        run(30);
        shadow_en_a = 1'b0; shadow_en_b = 1'b0;

        tag = "R5";
        updown = 1'b1;
        wa(4); wb(2);
        run(45);

        tag = "R6";
        act_word_a = 10'h030;
        act_word_b = 10'h303;
        run(45);
        act_word_a = 10'h021;
        act_word_b = 10'h012;
        run(40);

        tag = "R7";
        updown = 1'b0;
        dir_up = 1'b1;
        cnt = 0;
        act_word_a = 10'h312;
        act_word_b = 10'h023;
        wa(0); wb(0);
        run(30);
        act_word_a = 10'h022;
        act_word_b = 10'h031;
        wa(0); wb(5);
        run(30);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule